// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Common Clear Edge

This block turns one up-counter into three pulse-width-modulated waveforms, each driven on a pair of pins: a true output and its exact inverse. The counter starts at zero and climbs by one per clock. A period register ends every cycle by sending the counter back to zero. That clear instant is the one edge all three waveforms share: every true output rises there. Each phase then falls at its own programmable compare point. A separate cycle-marker output flips once per period, on the same clock as the clear.

Software or a neighbouring block loads the period and the three compare values through a one-cycle write port. Writes land on the next clock edge and never reset the running count. A two-state sequencer, HALT and COUNT, gates the counter from the enable input. In HALT the count and the cycle marker freeze, every true output is low and every inverse output is high.

The sequencer has two transitions. GO (HALT to COUNT) fires when enable is seen high. STOP (COUNT to HALT) fires when enable is seen low. Synchronous reset forces HALT.

Top module: `rsync_pwm3`

## Requirements
- R1: While and right after synchronous reset, the counter, the period register, all compare registers and `cyc_tgl` are zero, the sequencer is in HALT, `pwm_p` is 3'b000 and `pwm_n` is 3'b111.
- R2: When `wr_en` is high at a clock edge, `wr_sel` picks the target register: 0 is the period register, 1 is the phase 0 compare, 2 is the phase 1 compare and 3 is the phase 2 compare. The new value is used from that edge on, and the write does not change the count.
- R3: In COUNT, when the count is below the period value, the count rises by one each clock. The sequencer enters COUNT on the clock where `en` is seen high, and counting starts on the following clock.
- R4: In COUNT, when the count is equal to or above the period value, the next clock returns the count to zero. This also covers a period that is rewritten below the current count.
- R5: `cyc_tgl` inverts on exactly the clocks where the count is cleared to zero, and at no other time.
- R6: In COUNT, `pwm_p[i]` is high while the count is below phase i's compare value, and low from the compare match until the next clear.
- R7: A compare value above the period keeps that phase high for the whole period. A compare value of zero keeps that phase low for the whole period.
- R8: `pwm_n[i]` is always the inverse of `pwm_p[i]`.
- R9: When `en` is seen low, the sequencer enters HALT on that clock. In HALT the count and `cyc_tgl` hold, `pwm_p` is all low and `pwm_n` is all high. After the next GO, counting resumes from the held count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable, sampled by the sequencer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 to 3 phase compares |
| wr_data | input | W | Write value |
| pwm_p | output | 3 | True PWM outputs, one per phase |
| pwm_n | output | 3 | Inverse PWM outputs, one per phase |
| cyc_tgl | output | 1 | Flips once per PWM period |

## Verification
The checker watches the counter and sequencer on every clock. It checks that the count steps by one below the period, clears at or above it, and holds in HALT. It checks that `cyc_tgl` moves only with a clear, and that the outputs are in their parked levels whenever the block is halted.

The pulse positions of each phase, the compare corner cases (above the period and zero), the timing of a write, and resuming from a held count can only be shown by the bench. The bench runs directed and random scenarios against its own cycle model and compares all pins every clock.

// File: rtl/rsync_pwm3_pkg.sv
package rsync_pwm3_pkg;
    localparam int NPH  = 3;
    localparam int SELW = $clog2(NPH + 1);

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_st_t;
endpackage

// File: rtl/rsync_pwm3_regs.sv
module rsync_pwm3_regs
    import rsync_pwm3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SELW-1:0]     wr_sel,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        period,
    output logic [NPH-1:0][W-1:0] cmp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            period <= '0;
        end else if (wr_en && wr_sel == SELW'(0)) begin
            period <= wr_data;
        end
    end

    for (genvar g = 0; g < NPH; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp[g] <= '0;
            end else if (wr_en && wr_sel == SELW'(g + 1)) begin
                cmp[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/rsync_pwm3_seq.sv
module rsync_pwm3_seq
    import rsync_pwm3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         run,
    output logic         tgl
);
    run_st_t state, state_nx;
    logic    wrap;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HALT;
        else     state <= state_nx;
    end

    // transitions: GO and STOP
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:  if (en)  state_nx = ST_COUNT;
            ST_COUNT: if (!en) state_nx = ST_HALT;
            default:  state_nx = ST_HALT;
        endcase
    end

    assign run  = (state == ST_COUNT);
    assign wrap = run && (cnt >= period);

    // counter and cycle marker
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            tgl <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            tgl <= ~tgl;
        end else if (run) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/rsync_pwm3_phase.sv
module rsync_pwm3_phase #(
    parameter int W = 8
) (
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         hi,
    output logic         lo
);
    logic active;

    always_comb begin
        active = run && (cnt < cmp);
        hi     = active;
        lo     = ~active;
    end
endmodule

// File: rtl/rsync_pwm3.sv
module rsync_pwm3
    import rsync_pwm3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [W-1:0]    wr_data,
    output logic [NPH-1:0]  pwm_p,
    output logic [NPH-1:0]  pwm_n,
    output logic            cyc_tgl
);
    logic [W-1:0]          period;
    logic [NPH-1:0][W-1:0] cmp;
    logic [W-1:0]          cnt;
    logic                  run;

    rsync_pwm3_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .period(period), .cmp(cmp)
    );

    rsync_pwm3_seq #(.W(W)) u_seq (
        .clk(clk), .rst(rst), .en(en), .period(period),
        .cnt(cnt), .run(run), .tgl(cyc_tgl)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_ph
        rsync_pwm3_phase #(.W(W)) u_ph (
            .run(run), .cnt(cnt), .cmp(cmp[g]),
            .hi(pwm_p[g]), .lo(pwm_n[g])
        );
    end
endmodule

// File: rtl/rsync_pwm3_chk.sv
module rsync_pwm3_chk
    import rsync_pwm3_pkg::*;
#(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           run,
    input logic [W-1:0]   cnt,
    input logic [W-1:0]   period,
    input logic [NPH-1:0] pwm_p,
    input logic [NPH-1:0] pwm_n,
    input logic           cyc_tgl
);
    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt < period) |=> (cnt == $past(cnt) + W'(1)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt >= period) |=> (cnt == '0));

    // R5
    tgl_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt >= period) |=> (cyc_tgl != $past(cyc_tgl)));

    // R5
    tgl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(run && cnt >= period) |=> $stable(cyc_tgl));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt));

    // R9
    halt_park_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pwm_p == '0 && pwm_n == '1));

    // R8
    pair_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm_n == ~pwm_p));
endmodule

bind rsync_pwm3 rsync_pwm3_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt), .period(period),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .cyc_tgl(cyc_tgl)
);

// File: tb/sim_rsync_pwm3.sv
module sim_rsync_pwm3;
    localparam int W      = 8;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   pwm_p, pwm_n;
    logic         cyc_tgl;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    string tag = "R1";

    always #(CLK_NS/2) clk = ~clk;

    rsync_pwm3 #(.W(W)) u0 (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_p(pwm_p), .pwm_n(pwm_n), .cyc_tgl(cyc_tgl)
    );

    // independent cycle model
    logic         m_run = 1'b0;
    logic [W-1:0] m_cnt = '0;
    logic         m_tgl = 1'b0;
    logic [W-1:0] m_per = '0;
    logic [W-1:0] m_cmp [3];

    initial for (int k = 0; k < 3; k++) m_cmp[k] = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 1'b0; m_cnt = '0; m_tgl = 1'b0; m_per = '0;
            for (int k = 0; k < 3; k++) m_cmp[k] = '0;
        end else begin
            if (m_run) begin
                if (m_cnt >= m_per) begin m_cnt = '0; m_tgl = ~m_tgl; end
                else m_cnt = m_cnt + 1'b1;
            end
            m_run = en;
            if (wr_en) begin
                if (wr_sel == 2'd0) m_per = wr_data;
                else m_cmp[wr_sel - 2'd1] = wr_data;
            end
        end
    end

    function automatic logic [2:0] exp_p();
        logic [2:0] r;
        for (int k = 0; k < 3; k++) r[k] = m_run && (m_cnt < m_cmp[k]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // advance one clock, then compare all pins away from the edge
    task automatic cyc();
        @(negedge clk);
        chk(tag,  {5'd0, pwm_p}, {5'd0, exp_p()});
        chk("R8", {5'd0, pwm_n}, {5'd0, ~exp_p()});
        chk("R5", {7'd0, cyc_tgl}, {7'd0, m_tgl});
    endtask

    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        if (!done) $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {5'd0, pwm_p}, 8'h00);
        chk("R1", {5'd0, pwm_n}, 8'h07);
        chk("R1", {7'd0, cyc_tgl}, 8'h00);
        rst = 1'b0;
        cyc();

        // R2: program period 9 and compares 3, 6, 0 (R7 zero case)
        tag = "R2";
        wr(2'd0, 8'd9); wr(2'd1, 8'd3); wr(2'd2, 8'd6); wr(2'd3, 8'd0);
        // R3 R4 R6: free running
        tag = "R6";
        en = 1'b1;
        run_n(40);

        // R7: compare above period stays high, zero stays low
        tag = "R7";
        wr(2'd1, 8'd20);
        run_n(25);

        // R9: stop, hold, resume
        tag = "R9";
        run_n(4);
        en = 1'b0;
        run_n(10);
        en = 1'b1;
        run_n(15);

        // R2: rewrite a compare mid-period without disturbing count
        tag = "R2";
        wr(2'd2, 8'd2);
        run_n(6);
        wr(2'd2, 8'd8);
        run_n(12);

        // R4: enlarge period, then shrink it below the running count
        tag = "R4";
        wr(2'd0, 8'd30);
        run_n(20);
        wr(2'd0, 8'd5);
        run_n(20);

        // R3: random mix of writes and enable
        tag = "R3";
        for (int i = 0; i < 600; i++) begin
            en = ($urandom % 10) != 0;
            if (($urandom % 8) == 0) begin
                wr_en = 1'b1;
                wr_sel = 2'($urandom % 4);
                wr_data = W'($urandom % 18);
            end
            cyc();
            wr_en = 1'b0;
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule